// File: doc/BRIEF.md
# Two-Channel DMA Bus Arbiter

This block decides, one transfer-unit slot at a time, who owns a shared bus. There are three possible owners: the CPU, DMA channel 0 and DMA channel 1. The CPU is the default owner. Each channel has three inputs. The first is a pending-request level. The second is a mode bit that selects burst transfer or cycle-steal transfer. The third is a done flag, which marks the channel's final transfer unit while the channel holds the bus.

The surrounding bus logic pulses `slot_end` in the last cycle of each transfer unit. The grant registers take a new value only on a clock edge where `slot_end` is high. The arbiter has two policies. Fixed priority puts channel 0 above channel 1. Round-robin makes the channel granted most recently the least favoured at the next decision.

Burst and cycle-steal channels interact in a defined way. A cycle-steal channel may preempt a bursting channel. When it does, the two share slots in turn and the CPU gets no slot in between. The bus goes back to the CPU only when no burst work remains. In round-robin mode both channels must run in the same mode. A mixed setting raises an error output, and the arbiter hands every following slot to the CPU.

Top module: `dma_bus_arbiter`

## Requirements
- R1: After reset `gnt_cpu` is 1, both channel grants are 0, and round-robin order starts with channel 0 favoured.
- R2: In every cycle exactly one of `gnt_cpu`, `gnt_ch0`, `gnt_ch1` is 1.
- R3: The grant outputs change only on a rising clock edge at which `slot_end` is 1. The new owner is visible in the cycle after that edge.
- R4: In fixed mode (`rr_mode`=0), channel 0 wins when both channels are eligible. A channel 0 request that arrives during a channel 1 burst takes the very next slot.
- R5: A channel whose `ch_burst` bit is 1 (burst mode) keeps each slot it wins. It releases the bus only when its `ch_done` bit (bit i for channel i) is 1 at a slot boundary while it holds the grant. A burst that was preempted resumes once the higher channel finishes.
- R6: A channel whose `ch_burst` bit is 0 (cycle-steal mode) cannot win two slots in a row. When it is the only requester, the slots go channel, CPU, channel, CPU.
- R7: A cycle-steal channel 0 that competes with a bursting channel 1 produces grants that alternate between channel 0 and channel 1, with no CPU slot.
- R8: The CPU gets a slot only when no channel is eligible. Any burst channel whose request is high and that has not just signalled done keeps the CPU off the bus.
- R9: In round-robin mode (`rr_mode`=1) the channel granted last has the lower priority at the next decision.
- R10: `mix_err` is 1 in the same cycle that `rr_mode`=1 and the two `ch_burst` bits differ. At any boundary where it is 1, the next slot goes to the CPU.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| slot_end | input | 1 | Last cycle of the current transfer unit |
| rr_mode | input | 1 | 1 = round-robin, 0 = fixed priority (channel 0 first) |
| ch_req | input | 2 | Pending request, bit i for channel i |
| ch_burst | input | 2 | 1 = burst, 0 = cycle-steal, bit i for channel i |
| ch_done | input | 2 | Final unit of the channel now granted, bit i for channel i |
| gnt_cpu | output | 1 | CPU owns the bus |
| gnt_ch0 | output | 1 | Channel 0 owns the bus |
| gnt_ch1 | output | 1 | Channel 1 owns the bus |
| mix_err | output | 1 | Illegal mode mix in round-robin mode |

## Verification
The bench starts a channel 0 request during a channel 1 burst. A design that waits for the burst to end, or that puts a CPU slot between the two channels, fails R4 or R7. It lets a lone cycle-steal channel run. A design without the one-slot give-back would hold the bus, and a design that over-applies it would starve burst channels. It marks done on a preempting burst and checks that the suspended burst resumes rather than the bus going back to the CPU. It runs round-robin order straight after reset and again after idle gaps, changes requests while `slot_end` is low, and raises the illegal mode mix to confirm that only the CPU is granted.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  localparam int NCH = 2;
  localparam int OWN_W = 2;
  typedef enum logic [OWN_W-1:0] {
    OWN_CPU = 2'd0,
    OWN_CH0 = 2'd1,
    OWN_CH1 = 2'd2
  } owner_e;
endpackage

// File: rtl/dma_arb_elig.sv
// A channel may take the next slot if it requests, and if it is not
// the current owner that has either finished or just used its one
// cycle-steal slot.
module dma_arb_elig #(
  parameter int NCH = 2
) (
  input  logic [NCH-1:0] req,
  input  logic [NCH-1:0] burst,
  input  logic [NCH-1:0] done,
  input  logic [NCH-1:0] cur,
  output logic [NCH-1:0] elig
);
  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign elig[i] = req[i] & ~(cur[i] & (done[i] | ~burst[i]));
  end
endmodule

// File: rtl/dma_arb_pick.sv
module dma_arb_pick
  import dma_arb_pkg::*;
(
  input  logic [1:0] elig,
  input  logic       rr_mode,
  input  logic       rr_hi,
  input  logic       err,
  output owner_e     nxt
);
  logic ch1_first;
  assign ch1_first = rr_mode & rr_hi;

  always_comb begin
    nxt = OWN_CPU;
    if (err) begin
      nxt = OWN_CPU;
    end else if (ch1_first) begin
      if (elig[1])      nxt = OWN_CH1;
      else if (elig[0]) nxt = OWN_CH0;
    end else begin
      if (elig[0])      nxt = OWN_CH0;
      else if (elig[1]) nxt = OWN_CH1;
    end
  end
endmodule

// File: rtl/dma_arb_state.sv
module dma_arb_state
  import dma_arb_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   slot_end,
  input  owner_e nxt,
  output owner_e owner_q,
  output logic   rr_hi_q
);
  owner_e owner_d;
  logic   rr_hi_d;

  always_comb begin
    owner_d = owner_q;
    rr_hi_d = rr_hi_q;
    if (slot_end) begin
      owner_d = nxt;
      case (nxt)
        OWN_CH0: rr_hi_d = 1'b1;
        OWN_CH1: rr_hi_d = 1'b0;
        default: rr_hi_d = rr_hi_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owner_q <= OWN_CPU;
      rr_hi_q <= 1'b0;
    end else begin
      owner_q <= owner_d;
      rr_hi_q <= rr_hi_d;
    end
  end
endmodule

// File: rtl/dma_bus_arbiter.sv
module dma_bus_arbiter
  import dma_arb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       slot_end,
  input  logic       rr_mode,
  input  logic [1:0] ch_req,
  input  logic [1:0] ch_burst,
  input  logic [1:0] ch_done,
  output logic       gnt_cpu,
  output logic       gnt_ch0,
  output logic       gnt_ch1,
  output logic       mix_err
);
  owner_e         owner_q;
  owner_e         nxt;
  logic           rr_hi_q;
  logic [NCH-1:0] cur;
  logic [NCH-1:0] elig;

  assign cur     = {owner_q == OWN_CH1, owner_q == OWN_CH0};
  assign mix_err = rr_mode & (ch_burst[0] ^ ch_burst[1]);

  dma_arb_elig #(.NCH(NCH)) elig_i (
    .req   (ch_req),
    .burst (ch_burst),
    .done  (ch_done),
    .cur   (cur),
    .elig  (elig)
  );

  dma_arb_pick pick_i (
    .elig    (elig),
    .rr_mode (rr_mode),
    .rr_hi   (rr_hi_q),
    .err     (mix_err),
    .nxt     (nxt)
  );

  dma_arb_state state_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .slot_end (slot_end),
    .nxt      (nxt),
    .owner_q  (owner_q),
    .rr_hi_q  (rr_hi_q)
  );

  assign gnt_cpu = (owner_q == OWN_CPU);
  assign gnt_ch0 = (owner_q == OWN_CH0);
  assign gnt_ch1 = (owner_q == OWN_CH1);
endmodule

// File: rtl/dma_arb_checker.sv
module dma_arb_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       slot_end,
  input logic       rr_mode,
  input logic [1:0] ch_req,
  input logic [1:0] ch_burst,
  input logic [1:0] ch_done,
  input logic       gnt_cpu,
  input logic       gnt_ch0,
  input logic       gnt_ch1,
  input logic       mix_err
);
  logic [2:0] g;
  assign g = {gnt_ch1, gnt_ch0, gnt_cpu};

  a_r2_one_owner: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(g) == 1);

  a_r3_hold_mid_slot: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_end |=> $stable(g));

  a_r5_burst_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    slot_end && !rr_mode && gnt_ch0 && ch_burst[0] && ch_req[0] && !ch_done[0]
    |=> gnt_ch0);

  a_r6_steal_gives_up: assert property (@(posedge clk) disable iff (!rst_n)
    slot_end && gnt_ch0 && !ch_burst[0] |=> !gnt_ch0);

  a_r8_burst_blocks_cpu: assert property (@(posedge clk) disable iff (!rst_n)
    slot_end && !mix_err && ch_req[1] && ch_burst[1] && !(gnt_ch1 && ch_done[1])
    |=> !gnt_cpu);

  a_r10_err_to_cpu: assert property (@(posedge clk) disable iff (!rst_n)
    slot_end && mix_err |=> gnt_cpu);
endmodule

bind dma_bus_arbiter dma_arb_checker chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .slot_end (slot_end),
  .rr_mode  (rr_mode),
  .ch_req   (ch_req),
  .ch_burst (ch_burst),
  .ch_done  (ch_done),
  .gnt_cpu  (gnt_cpu),
  .gnt_ch0  (gnt_ch0),
  .gnt_ch1  (gnt_ch1),
  .mix_err  (mix_err)
);

// File: tb/dma_bus_arbiter_tb_top.sv
module dma_bus_arbiter_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk;
  logic       rst_n;
  logic       slot_end;
  logic       rr_mode;
  logic [1:0] ch_req;
  logic [1:0] ch_burst;
  logic [1:0] ch_done;
  logic       gnt_cpu;
  logic       gnt_ch0;
  logic       gnt_ch1;
  logic       mix_err;

  int checks;
  int errors;

  localparam logic [2:0] G_CPU = 3'b001;
  localparam logic [2:0] G_CH0 = 3'b010;
  localparam logic [2:0] G_CH1 = 3'b100;

  dma_bus_arbiter dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .slot_end (slot_end),
    .rr_mode  (rr_mode),
    .ch_req   (ch_req),
    .ch_burst (ch_burst),
    .ch_done  (ch_done),
    .gnt_cpu  (gnt_cpu),
    .gnt_ch0  (gnt_ch0),
    .gnt_ch1  (gnt_ch1),
    .mix_err  (mix_err)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check_bits(input logic [2:0] act, input logic [2:0] exp,
                            input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // one clock edge, then sample the grants at the falling edge
  task automatic slot(input logic [2:0] exp, input string tag);
    @(posedge clk);
    @(negedge clk);
    check_bits({gnt_ch1, gnt_ch0, gnt_cpu}, exp, tag);
  endtask

  task automatic do_reset;
    rst_n = 1'b0;
    slot_end = 1'b1; rr_mode = 1'b0;
    ch_req = 2'b00; ch_burst = 2'b00; ch_done = 2'b00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset;
    do_reset();
    check_bits({gnt_ch1, gnt_ch0, gnt_cpu}, G_CPU, "R1 reset owner");
    check_bits({2'b00, mix_err}, 3'b000, "R1 reset err");
    check_bits({2'b00, gnt_cpu ^ gnt_ch0 ^ gnt_ch1}, 3'b001, "R2 one grant");
  endtask

  task automatic t_lone_steal;
    ch_burst = 2'b00; ch_req = 2'b01;
    slot(G_CH0, "R6 steal slot 1");
    slot(G_CPU, "R6 cpu slot 1");
    slot(G_CH0, "R6 steal slot 2");
    slot(G_CPU, "R6 cpu slot 2");
    ch_req = 2'b00;
    slot(G_CPU, "R8 idle");
  endtask

  task automatic t_burst_preempt;
    ch_burst = 2'b11; ch_req = 2'b10;
    slot(G_CH1, "R5 ch1 burst start");
    slot(G_CH1, "R5 ch1 burst hold");
    ch_req = 2'b11;
    slot(G_CH0, "R4 ch0 preempts");
    slot(G_CH0, "R5 ch0 burst hold");
    ch_done = 2'b01;
    slot(G_CH1, "R5 ch1 resumes");
    ch_req = 2'b10; ch_done = 2'b00;
    slot(G_CH1, "R5 ch1 continues");
    ch_done = 2'b10;
    slot(G_CPU, "R8 cpu after bursts");
    ch_req = 2'b00; ch_done = 2'b00;
    ch_req = 2'b11;
    slot(G_CH0, "R4 fixed simultaneous");
    ch_done = 2'b01;
    slot(G_CH1, "R5 ch1 after ch0 done");
    ch_req = 2'b10; ch_done = 2'b10;
    slot(G_CPU, "R8 all done");
    ch_req = 2'b00; ch_done = 2'b00;
  endtask

  task automatic t_alternate;
    ch_burst = 2'b10; ch_req = 2'b10;
    slot(G_CH1, "R7 ch1 burst");
    ch_req = 2'b11;
    slot(G_CH0, "R7 alt ch0 a");
    slot(G_CH1, "R7 alt ch1 a");
    slot(G_CH0, "R7 alt ch0 b");
    slot(G_CH1, "R7 alt ch1 b");
    ch_req = 2'b10;
    slot(G_CH1, "R8 ch1 keeps bus");
    ch_done = 2'b10;
    slot(G_CPU, "R8 back to cpu");
    ch_req = 2'b00; ch_done = 2'b00;
  endtask

  task automatic t_hold;
    ch_burst = 2'b10; ch_req = 2'b10; slot_end = 1'b0;
    slot(G_CPU, "R3 no boundary a");
    slot(G_CPU, "R3 no boundary b");
    slot_end = 1'b1;
    slot(G_CH1, "R3 boundary grants");
    slot_end = 1'b0; ch_req = 2'b11;
    slot(G_CH1, "R3 preempt waits a");
    slot(G_CH1, "R3 preempt waits b");
    slot_end = 1'b1; ch_req = 2'b01; ch_done = 2'b10;
    slot(G_CH0, "R3 boundary switch");
    ch_req = 2'b00; ch_done = 2'b00;
    slot(G_CPU, "R8 hold idle");
  endtask

  task automatic t_round_robin;
    do_reset();
    rr_mode = 1'b1; ch_burst = 2'b11; ch_req = 2'b11;
    slot(G_CH0, "R1 rr starts ch0");
    slot(G_CH1, "R9 rr ch1");
    slot(G_CH0, "R9 rr ch0");
    slot(G_CH1, "R9 rr ch1 again");
    ch_req = 2'b00;
    slot(G_CPU, "R8 rr idle");
    ch_req = 2'b11;
    slot(G_CH0, "R9 rr after gap");
    ch_req = 2'b00;
    slot(G_CPU, "R8 rr idle 2");
    ch_burst = 2'b00; ch_req = 2'b11;
    slot(G_CH1, "R9 rr steal ch1 first");
    slot(G_CH0, "R9 rr steal ch0");
    slot(G_CH1, "R9 rr steal ch1");
    ch_req = 2'b00;
    slot(G_CPU, "R8 rr idle 3");
  endtask

  task automatic t_mix_err;
    rr_mode = 1'b1; ch_burst = 2'b01; ch_req = 2'b11;
    #1;
    check_bits({2'b00, mix_err}, 3'b001, "R10 err raised");
    @(negedge clk);
    slot(G_CPU, "R10 cpu only a");
    slot(G_CPU, "R10 cpu only b");
    rr_mode = 1'b0;
    #1;
    check_bits({2'b00, mix_err}, 3'b000, "R10 err cleared fixed");
    @(negedge clk);
    slot(G_CH0, "R4 fixed ch0 burst");
    slot(G_CH0, "R5 fixed ch0 keeps");
    ch_done = 2'b01; ch_req = 2'b10;
    slot(G_CH1, "R6 ch1 steal slot");
    ch_done = 2'b00;
    slot(G_CPU, "R6 ch1 gives back");
    ch_req = 2'b00;
  endtask

  initial begin
    checks = 0;
    errors = 0;
    t_reset();
    t_lone_steal();
    t_burst_preempt();
    t_alternate();
    t_hold();
    t_round_robin();
    t_mix_err();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule